// File: doc/BRIEF.md
# Exception Return and Privilege Mode Controller

This block completes the return-from-exception instruction and works out the processor's privilege mode and interrupt gating from the live status bits. When the pipeline presents a return strobe, the block picks the nesting level to unwind. The error level is unwound before the exception level. The block then issues a one-cycle redirect carrying the restart address, together with a one-cycle pulse that tells the status register which level bit to clear. The status register itself lives outside this block.

The mode and interrupt outputs are combinational from the current status inputs. An active exception or error level forces kernel mode. It also blocks every interrupt, whatever the global enable says. User mode holds only when the user bit is set and both level bits are clear. Accesses to the system control coprocessor are granted in kernel mode and refused in user mode.

Top module: `eret_mode_ctrl`

## Requirements
- R1: A return strobe sampled while the error-level bit is 1 gives, one cycle later, `clr_erl`=1, `clr_exl`=0, `redir_valid`=1 and `redir_pc` equal to the error restart address sampled with the strobe. This holds even when the exception-level bit is also 1.
- R2: A return strobe sampled while the error-level bit is 0 and the exception-level bit is 1 gives, one cycle later, `clr_exl`=1, `clr_erl`=0, `redir_valid`=1 and `redir_pc` equal to the exception restart address sampled with the strobe.
- R3: A return strobe sampled while both level bits are 0 gives, one cycle later, `redir_valid`=1 with `redir_pc` equal to the exception restart address, and both clear pulses stay 0.
- R4: `redir_valid`, `clr_erl` and `clr_exl` are high only in the cycle directly after a cycle in which the return strobe was high. They are 0 in any cycle that follows a cycle with no strobe.
- R5: While either level bit is 1, `irq_req` is 0 for any combination of the enable bit, the mask and the pending lines.
- R6: While both level bits are 0, `irq_req` is 1 exactly when the enable bit is 1 and at least one pending line i has mask bit i set (bit i of `irq_pend` pairs with bit i of `st_im`).
- R7: `kernel_mode` is 0 only when the user bit is 1 and both level bits are 0. It is 1 in every other combination.
- R8: `cp0_grant` = `cp0_req` AND `kernel_mode`, and `cp0_fault` = `cp0_req` AND NOT `kernel_mode`. The two are never both 1.
- R9: While `rst_n` is 0, and in the first cycle after it rises with no strobe, `redir_valid`, `clr_erl`, `clr_exl` and `redir_pc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eret_i | input | 1 | Return-from-exception strobe, one per instruction |
| st_um | input | 1 | Status user-mode bit |
| st_erl | input | 1 | Status error-level bit |
| st_exl | input | 1 | Status exception-level bit |
| st_ie | input | 1 | Status global interrupt enable |
| st_im | input | NIRQ | Status per-line interrupt mask |
| irq_pend | input | NIRQ | Pending interrupt lines |
| epc | input | XLEN | Exception restart address |
| err_epc | input | XLEN | Error restart address |
| cp0_req | input | 1 | Control-coprocessor access attempt |
| redir_valid | output | 1 | One-cycle PC redirect strobe |
| redir_pc | output | XLEN | Redirect target |
| clr_erl | output | 1 | One-cycle pulse: clear error level |
| clr_exl | output | 1 | One-cycle pulse: clear exception level |
| kernel_mode | output | 1 | 1 = kernel, 0 = user |
| irq_req | output | 1 | Gated interrupt request |
| cp0_grant | output | 1 | Coprocessor access permitted |
| cp0_fault | output | 1 | Coprocessor access refused |

## Verification
A return strobe and the interrupt gate can land in the same cycle. The bench issues returns with a level bit still set while the enable bit is 1 and a masked-in line is pending. The gate must stay closed in that cycle, because the clear pulse only lands a cycle later. The other overlap is a return with both level bits set. The bench provokes it in a directed pass and again through random status patterns, and judges it against the model: only the error level is cleared and the error restart address is the target.

// File: rtl/eret_mode_ctrl.sv
module eret_mode_ctrl #(
  parameter int XLEN = 32,
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eret_i,
  input  logic            st_um,
  input  logic            st_erl,
  input  logic            st_exl,
  input  logic            st_ie,
  input  logic [NIRQ-1:0] st_im,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic [XLEN-1:0] epc,
  input  logic [XLEN-1:0] err_epc,
  input  logic            cp0_req,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output logic            clr_erl,
  output logic            clr_exl,
  output logic            kernel_mode,
  output logic            irq_req,
  output logic            cp0_grant,
  output logic            cp0_fault
);

  logic any_level;
  logic user_mode;

  assign any_level   = st_erl | st_exl;
  assign user_mode   = st_um & ~any_level;
  assign kernel_mode = ~user_mode;
  assign irq_req     = st_ie & ~any_level & (|(irq_pend & st_im));
  assign cp0_grant   = cp0_req & ~user_mode;
  assign cp0_fault   = cp0_req & user_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      clr_erl     <= 1'b0;
      clr_exl     <= 1'b0;
    end else begin
      redir_valid <= eret_i;
      clr_erl     <= eret_i & st_erl;
      clr_exl     <= eret_i & ~st_erl & st_exl;
      if (eret_i) redir_pc <= st_erl ? err_epc : epc;
    end
  end

  assert_err_unwind_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && st_erl) |=> (clr_erl && !clr_exl && redir_valid && redir_pc == $past(err_epc)));

  assert_exc_unwind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !st_erl && st_exl) |=> (clr_exl && !clr_erl && redir_valid && redir_pc == $past(epc)));

  assert_no_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !st_erl && !st_exl) |=> (!clr_exl && !clr_erl && redir_valid && redir_pc == $past(epc)));

  assert_pulse_only_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !eret_i |=> (!redir_valid && !clr_erl && !clr_exl));

  assert_level_masks_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_erl || st_exl) |-> !irq_req);

  assert_level_forces_kernel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_erl || st_exl || !st_um) |-> kernel_mode);

  assert_cp0_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cp0_grant, cp0_fault}) == (cp0_req ? 1 : 0));

endmodule

// File: tb/eret_mode_ctrl_test.sv
module eret_mode_ctrl_test;
  localparam int XLEN = 32;
  localparam int NIRQ = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eret_i = 0, st_um = 0, st_erl = 0, st_exl = 0, st_ie = 0, cp0_req = 0;
  logic [NIRQ-1:0] st_im = '0, irq_pend = '0;
  logic [XLEN-1:0] epc = '0, err_epc = '0;
  logic redir_valid, clr_erl, clr_exl, kernel_mode, irq_req, cp0_grant, cp0_fault;
  logic [XLEN-1:0] redir_pc;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  eret_mode_ctrl #(.XLEN(XLEN), .NIRQ(NIRQ)) uut (
    .clk(clk), .rst_n(rst_n), .eret_i(eret_i), .st_um(st_um), .st_erl(st_erl),
    .st_exl(st_exl), .st_ie(st_ie), .st_im(st_im), .irq_pend(irq_pend),
    .epc(epc), .err_epc(err_epc), .cp0_req(cp0_req), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .clr_erl(clr_erl), .clr_exl(clr_exl),
    .kernel_mode(kernel_mode), .irq_req(irq_req), .cp0_grant(cp0_grant),
    .cp0_fault(cp0_fault)
  );

  task automatic chk(input string what, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", what, got, exp);
    end
  endtask

  // one step: inputs already driven after a falling edge
  task automatic step();
    int lvl, ker, irq;
    int e_valid, e_cerl, e_cexl;
    logic [XLEN-1:0] e_pc;
    #1;
    lvl = (st_erl || st_exl) ? 1 : 0;
    ker = (st_um && lvl == 0) ? 0 : 1;
    irq = 0;
    if (lvl == 0 && st_ie) for (int i = 0; i < NIRQ; i++) if (st_im[i] && irq_pend[i]) irq = 1;
    chk("R7 kernel_mode", kernel_mode, ker);
    chk(lvl ? "R5 irq_req" : "R6 irq_req", irq_req, irq);
    chk("R8 cp0_grant", cp0_grant, (cp0_req && ker) ? 1 : 0);
    chk("R8 cp0_fault", cp0_fault, (cp0_req && !ker) ? 1 : 0);
    e_valid = eret_i ? 1 : 0;
    e_cerl = 0; e_cexl = 0; e_pc = epc;
    if (eret_i && st_erl) begin e_cerl = 1; e_pc = err_epc; end
    else if (eret_i && st_exl) e_cexl = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R4 redir_valid", redir_valid, e_valid);
    chk("R1 clr_erl", clr_erl, e_cerl);
    chk("R2 clr_exl", clr_exl, e_cexl);
    if (e_valid == 1) chk(e_cerl ? "R1 redir_pc" : (e_cexl ? "R2 redir_pc" : "R3 redir_pc"), redir_pc, e_pc);
  endtask

  task automatic setst(input logic e, input logic um, input logic erl, input logic exl, input logic ie);
    eret_i = e; st_um = um; st_erl = erl; st_exl = exl; st_ie = ie;
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    epc = 32'h8000_1000; err_epc = 32'hBFC0_0040;
    eret_i = 1'b1; st_erl = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset redir_valid", redir_valid, 0);
    chk("R9 reset clr_erl", clr_erl, 0);
    chk("R9 reset clr_exl", clr_exl, 0);
    chk("R9 reset redir_pc", redir_pc, 0);
    eret_i = 0; st_erl = 0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 post-reset redir_valid", redir_valid, 0);
    chk("R9 post-reset redir_pc", redir_pc, 0);

    // R1 with both levels set, interrupt pending and enabled in same cycle
    st_im = 8'h81; irq_pend = 8'h01;
    setst(1, 1, 1, 1, 1); step();
    setst(0, 1, 0, 1, 1); step();           // R4 pulse ends
    setst(1, 1, 0, 1, 1); step();           // R2
    setst(0, 1, 0, 0, 1); step();           // R6 irq fires, user mode
    setst(1, 0, 0, 0, 0); step();           // R3
    setst(1, 0, 0, 0, 0); epc = 32'h1234_5678; step(); // back-to-back R4
    cp0_req = 1;
    setst(0, 1, 0, 0, 1); irq_pend = 8'h7E; step(); // R6 masked off, R8 fault
    setst(0, 1, 1, 0, 1); step();           // R8 grant via level
    cp0_req = 0;

    for (int n = 0; n < 400; n++) begin
      eret_i = $urandom_range(0, 1);
      st_um = $urandom_range(0, 1);
      st_erl = $urandom_range(0, 1);
      st_exl = $urandom_range(0, 1);
      st_ie = $urandom_range(0, 1);
      st_im = NIRQ'($urandom);
      irq_pend = NIRQ'($urandom);
      epc = $urandom;
      err_epc = $urandom;
      cp0_req = $urandom_range(0, 1);
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule